// File: doc/BRIEF.md
# Non-volatile byte store access sequencer

This block sits between a CPU register bus and an on-chip non-volatile byte array. Software reaches it through three byte-wide registers: an address register, a data register and a control register. A read is a single strobe: the array's byte at the held address is latched into the data register at once, and the CPU is held for a fixed number of cycles. A write is guarded by a two-step handshake. Software first arms the write, then fires the write strobe. If the strobe comes too late the arm has already lapsed and the strobe is dropped.

An accepted write pulses the array's program input for one cycle and raises a busy flag. The busy flag clears by itself only after a fixed number of ticks from a calibrated oscillator, and software polls it. While busy is set, reads and address updates are refused. When the arm write selects mode 0b11, the accepted strobe pulses a flush of the array's temporary page buffer instead of programming, and busy stays low. Every accepted write and every read also raises a CPU stall request for a fixed number of cycles.

The controller is a three-state machine. In IDLE nothing is pending. ARMED is entered from IDLE on an arm write and holds a countdown. In ARMED an arm write reloads the countdown. From ARMED there are three exits: the write strobe goes to PROG when the mode is not 0b11, the write strobe goes back to IDLE with a flush pulse when the mode is 0b11, and the countdown expiring goes back to IDLE. PROG returns to IDLE when the oscillator tick count reaches the programming length.

Top module: `nvm_access_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the arm, the busy flag, the timer and the stall counter are cleared, so busy, stall and the control readback are all zero after reset.
- R2: Register select codes are 0 for address, 1 for data and 2 for control. Control write bits: bit 0 is the read strobe, bit 1 is the write strobe, bit 2 is arm, and bits 5:4 are the mode. A write with bit 1 set is treated as a write strobe only. Control readback: bit 1 is busy, bit 2 is armed, bits 5:4 are the mode, and all other bits read 0.
- R3: A write strobe on any of the ARM_WIN (4) clock edges that follow the arm write is accepted. It pulses arr_prog for one cycle with the held address and data, and busy rises.
- R4: A write strobe on edge ARM_WIN+1 or later after the arm write is ignored. The arm has expired, and busy stays low.
- R5: A write strobe with no preceding arm is ignored, and busy stays low.
- R6: Once a write starts, busy stays high until PROG_TICKS osc_tick pulses have been counted. It falls at the edge that counts the last pulse.
- R7: An accepted write strobe raises stall for exactly WR_STALL (2) cycles.
- R8: A read strobe loads the array byte at the held address into the data register on the same edge, and raises stall for exactly RD_STALL (4) cycles.
- R9: While busy is high, a read strobe is ignored: the data register keeps its value and arr_rd stays low.
- R10: While busy is high, writes to the address register are ignored.
- R11: The mode is captured by the arm write. When it is 0b11, the accepted write strobe pulses arr_flush instead of arr_prog, busy stays low, and the array is not programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Single-cycle enable from the calibrated oscillator |
| bus_we | input | 1 | Register write strobe from the CPU |
| bus_sel | input | 2 | Register select (0 address, 1 data, 2 control) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected register |
| stall | output | 1 | CPU stall request |
| busy | output | 1 | Programming in progress |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data at arr_addr |
| arr_rd | output | 1 | One-cycle array read pulse |
| arr_prog | output | 1 | One-cycle program pulse |
| arr_flush | output | 1 | One-cycle page-buffer flush pulse |

## Verification
The bench builds the block with ADDR_W = 4 and PROG_TICKS = 6. It keeps ARM_WIN = 4, WR_STALL = 2 and RD_STALL = 4. Six ticks bring the full busy interval within reach, so the busy edge can be checked one tick before and exactly at the end of the count. The 16-byte array lets a vector table program and read back bytes at both ends of the address range. The arm window is tested at the last accepted edge and at the first rejected edge.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PROG  = 2'd2
    } nvm_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int RSTB_BIT = 0;
    localparam int WSTB_BIT = 1;
    localparam int ARM_BIT  = 2;
    localparam int MODE_LO  = 4;
    localparam int MODE_HI  = 5;

    localparam logic [1:0] MODE_FLUSH = 2'b11;
endpackage

// File: rtl/nvm_regs.sv
module nvm_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    input  logic              busy,
    input  logic              arm_req,
    input  logic              rd_req,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q,
    output logic [1:0]        mode_q
);
    import nvm_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mode_q <= '0;
        end else begin
            if (bus_we && bus_sel == SEL_ADDR && !busy)
                addr_q <= bus_wdata[ADDR_W-1:0];
            if (rd_req)
                data_q <= arr_rdata;
            else if (bus_we && bus_sel == SEL_DATA)
                data_q <= bus_wdata;
            if (arm_req && !busy)
                mode_q <= bus_wdata[MODE_HI:MODE_LO];
        end
    end
endmodule

// File: rtl/nvm_fsm.sv
module nvm_fsm #(
    parameter int ARM_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic strobe_req,
    input  logic flush_sel,
    input  logic done,
    output logic busy,
    output logic armed,
    output logic prog_pulse,
    output logic flush_pulse
);
    import nvm_pkg::*;

    localparam int AW = $clog2(ARM_WIN + 1);
    localparam logic [AW-1:0] ARM_LOAD = AW'(ARM_WIN);
    localparam logic [AW-1:0] ARM_ONE  = AW'(1);

    nvm_state_e      state, state_nxt;
    logic [AW-1:0]   arm_cnt, arm_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            arm_cnt <= '0;
        end else begin
            state   <= state_nxt;
            arm_cnt <= arm_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        arm_nxt   = '0;
        unique case (state)
            ST_IDLE: begin
                if (arm_req) begin
                    state_nxt = ST_ARMED;
                    arm_nxt   = ARM_LOAD;
                end
            end
            ST_ARMED: begin
                if (strobe_req) begin
                    state_nxt = flush_sel ? ST_IDLE : ST_PROG;
                end else if (arm_req) begin
                    arm_nxt = ARM_LOAD;
                end else if (arm_cnt == ARM_ONE) begin
                    state_nxt = ST_IDLE;
                end else begin
                    arm_nxt = arm_cnt - ARM_ONE;
                end
            end
            ST_PROG: begin
                if (done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy        = 1'b0;
        armed       = 1'b0;
        prog_pulse  = 1'b0;
        flush_pulse = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ARMED: begin
                armed       = 1'b1;
                prog_pulse  = strobe_req && !flush_sel;
                flush_pulse = strobe_req && flush_sel;
            end
            ST_PROG:  busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
    parameter int PROG_TICKS = 26368
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(PROG_TICKS);
    localparam logic [CW-1:0] LAST = CW'(PROG_TICKS - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
    parameter int WR_STALL = 2,
    parameter int RD_STALL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_wr,
    input  logic load_rd,
    output logic stall
);
    localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
    localparam int SW   = $clog2(MAXS + 1);

    logic [SW-1:0] cnt;

    assign stall = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_wr)
            cnt <= SW'(WR_STALL);
        else if (load_rd)
            cnt <= SW'(RD_STALL);
        else if (cnt != '0)
            cnt <= cnt - SW'(1);
    end
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int ARM_WIN    = 4,
    parameter int PROG_TICKS = 26368,
    parameter int WR_STALL   = 2,
    parameter int RD_STALL   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              stall,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata,
    output logic              arr_rd,
    output logic              arr_prog,
    output logic              arr_flush
);
    import nvm_pkg::*;

    logic              ctrl_wr, arm_req, strobe_req, rd_req;
    logic              armed, done;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [1:0]        mode_q;

    assign ctrl_wr    = bus_we && (bus_sel == SEL_CTRL);
    assign strobe_req = ctrl_wr && bus_wdata[WSTB_BIT];
    assign arm_req    = ctrl_wr && bus_wdata[ARM_BIT] && !bus_wdata[WSTB_BIT];
    assign rd_req     = ctrl_wr && bus_wdata[RSTB_BIT] && !bus_wdata[WSTB_BIT] && !busy;

    nvm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .arm_req   (arm_req),
        .rd_req    (rd_req),
        .arr_rdata (arr_rdata),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .mode_q    (mode_q)
    );

    nvm_fsm #(.ARM_WIN(ARM_WIN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_req     (arm_req),
        .strobe_req  (strobe_req),
        .flush_sel   (mode_q == MODE_FLUSH),
        .done        (done),
        .busy        (busy),
        .armed       (armed),
        .prog_pulse  (arr_prog),
        .flush_pulse (arr_flush)
    );

    nvm_timer #(.PROG_TICKS(PROG_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (osc_tick),
        .done  (done)
    );

    nvm_stall #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_wr (arr_prog || arr_flush),
        .load_rd (rd_req),
        .stall   (stall)
    );

    assign arr_addr  = addr_q;
    assign arr_wdata = data_q;
    assign arr_rd    = rd_req;

    always_comb begin
        unique case (bus_sel)
            SEL_ADDR: bus_rdata = 8'(addr_q);
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = {2'b00, mode_q, 1'b0, armed, busy, 1'b0};
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvm_access_ctrl_chk.sv
module nvm_access_ctrl_chk #(
    parameter int ADDR_W  = 8,
    parameter int ARM_WIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              armed,
    input logic              stall,
    input logic              osc_tick,
    input logic              arm_req,
    input logic              arr_rd,
    input logic              arr_prog,
    input logic              arr_flush,
    input logic [ADDR_W-1:0] arr_addr
);
    localparam int GW = $clog2(ARM_WIN + 1) + 1;
    logic [GW-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n || arm_req || !armed)
            age <= '0;
        else if (age != '1)
            age <= age + GW'(1);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busy && !armed && !stall));

    a_r4_arm_expires: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (age < GW'(ARM_WIN)));

    a_r5_busy_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed) && $past(arr_prog));

    a_r6_busy_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !osc_tick) |=> busy);

    a_r7_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_prog || arr_flush) |=> stall);

    a_r8_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |=> stall);

    a_r9_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arr_rd);

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arr_addr));

    a_r11_flush_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_flush |=> !busy);
endmodule

bind nvm_access_ctrl nvm_access_ctrl_chk #(.ADDR_W(ADDR_W), .ARM_WIN(ARM_WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .armed     (armed),
    .stall     (stall),
    .osc_tick  (osc_tick),
    .arm_req   (arm_req),
    .arr_rd    (arr_rd),
    .arr_prog  (arr_prog),
    .arr_flush (arr_flush),
    .arr_addr  (arr_addr)
);

// File: tb/nvm_access_ctrl_test.sv
`timescale 1ns/1ps
module nvm_access_ctrl_test;
    localparam int AW    = 4;
    localparam int TICKS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stall, busy;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_wdata, arr_rdata;
    logic       arr_rd, arr_prog, arr_flush;

    logic [7:0] mem [16];
    int         flush_cnt = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    always #10 clk = ~clk;

    nvm_access_ctrl #(.ADDR_W(AW), .PROG_TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stall(stall), .busy(busy), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .arr_rd(arr_rd), .arr_prog(arr_prog), .arr_flush(arr_flush)
    );

    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (arr_prog) mem[arr_addr] <= arr_wdata;
        if (arr_flush) flush_cnt <= flush_cnt + 1;
    end

    // {address[11:8], data[7:0]}
    localparam logic [11:0] VEC [6] = '{
        12'h0_A5, 12'hF_3C, 12'h7_00, 12'h8_FF, 12'h1_5A, 12'hE_81
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; the write takes effect at the next posedge
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic tick1();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && busy; i++) tick1();
    endtask

    task automatic stall_len(output int n);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (stall) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < 16; i++) mem[i] = 8'h11 * i[7:0];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 stall", int'(stall), 0);
        rd(2'd2, v); chk("R1 ctrl", int'(v), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 table: program then read back each vector
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, {4'h0, VEC[k][11:8]});
            wr(2'd1, VEC[k][7:0]);
            wr(2'd2, 8'h04);
            rd(2'd2, v); chk("R2 armed readback", int'(v), 8'h04);
            wr(2'd2, 8'h02);
            chk("R3 busy after strobe", int'(busy), 1);
            rd(2'd2, v); chk("R2 busy readback", int'(v), 8'h02);
            drain();
            wr(2'd1, 8'h00);
            wr(2'd2, 8'h01);
            rd(2'd1, v); chk("R8 readback", int'(v), int'(VEC[k][7:0]));
            rd(2'd0, v); chk("R2 addr readback", int'(v), int'(VEC[k][11:8]));
            repeat (5) @(negedge clk);
        end

        // R3: strobe on the 4th edge after arm accepted
        wr(2'd0, 8'h02); wr(2'd1, 8'h77);
        wr(2'd2, 8'h04);
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h02);
        chk("R3 last window edge", int'(busy), 1);
        // R6: busy length
        for (int i = 0; i < TICKS - 1; i++) tick1();
        chk("R6 busy before last tick", int'(busy), 1);
        repeat (3) @(negedge clk);
        chk("R6 no ticks no clear", int'(busy), 1);
        tick1();
        chk("R6 busy after last tick", int'(busy), 0);
        chk("R3 programmed", int'(mem[2]), 8'h77);

        // R4: strobe on the 5th edge is ignored
        wr(2'd2, 8'h04);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R4 arm expired", int'(v), 0);
        wr(2'd2, 8'h02);
        chk("R4 late strobe", int'(busy), 0);

        // R5: strobe without arm
        wr(2'd1, 8'h99);
        wr(2'd2, 8'h02);
        chk("R5 no arm busy", int'(busy), 0);
        chk("R5 no arm mem", int'(mem[2]), 8'h77);

        // R7: write stall length
        wr(2'd2, 8'h04);
        wr(2'd2, 8'h02);
        stall_len(n);
        chk("R7 write stall", n, 2);
        drain();

        // R8: read stall length and immediate data
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R8 immediate data", int'(v), 8'h55);
        stall_len(n);
        chk("R8 read stall", n, 4);

        // R9/R10: read and address write during busy
        wr(2'd0, 8'h03); wr(2'd1, 8'hC3);
        wr(2'd2, 8'h04); wr(2'd2, 8'h02);
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R9 read ignored while busy", int'(v), 8'hC3);
        wr(2'd0, 8'h09);
        rd(2'd0, v); chk("R10 addr blocked while busy", int'(v), 3);
        drain();
        chk("R9 program done", int'(mem[3]), 8'hC3);

        // R11: flush mode
        wr(2'd0, 8'h06); wr(2'd1, 8'h01);
        wr(2'd2, 8'h34);
        rd(2'd2, v); chk("R11 mode readback", int'(v), 8'h34);
        wr(2'd2, 8'h02);
        chk("R11 flush not busy", int'(busy), 0);
        chk("R11 stall on flush", int'(stall), 1);
        @(negedge clk);
        chk("R11 flush pulse", flush_cnt, 1);
        chk("R11 not programmed", int'(mem[6]), 8'h66);

        // R1: reset while busy
        wr(2'd2, 8'h04); wr(2'd2, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy cleared", int'(busy), 0);
        rd(2'd2, v); chk("R1 ctrl cleared", int'(v), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule